// File: doc/BRIEF.md
# Parallel-port enhanced cycle gate with sticky timeout

This block sits on the host register side of a parallel port. It decodes byte-offset register accesses. It keeps shadow copies of the data byte and the control byte. It decides which accesses are passed on to the peripheral side, and which are completed locally or dropped.

Enhanced address cycles (offset 3) and enhanced data cycles (offset 4) reach the peripheral only when the control byte is in one exact configuration. That configuration is different for writes and for reads. Forwarded work is split into single-byte beats on a request/acknowledge link. Each beat is given a programmable number of cycles to be acknowledged. A beat that is not acknowledged in time ends the access and sets a sticky timeout flag. The flag appears in bit 0 of the status byte.

The host issues an access by raising `host_req` while `host_ready` is high. It then waits for the one-cycle `host_done` pulse. Read results are valid on `host_rdata` during that pulse.

Top module: `epp_cycle_gate`

## Requirements
- R1: After reset, offset 2 reads 0xCC, offset 0 reads 0xFF, the timeout flag is 0, `host_ready` is high and `per_req` is low. Every read returns its byte in bits 7:0 with all upper bits set to 1.
- R2: A write to offset 3 or 4 is forwarded only when (control & 0x2F) == 0x04. Otherwise it completes with no peripheral request.
- R3: A read from offset 3 or 4 is forwarded only when (control & 0x2F) == 0x24. Otherwise it completes with no peripheral request and returns all ones.
- R4: Each forwarded beat raises `per_req` with a kind code until `per_ack` is seen. The kind codes are: 0 data write, 1 control write, 2 direction change, 3 address write, 4 data-cycle write, 5 address read, 6 data-cycle read. `host_ready` is low while beats are in progress.
- R5: Offset-4 accesses move 1, 2 or 4 bytes for `host_size` 0, 1 or 2, least significant byte first. On reads, bytes that were never received stay 0xFF.
- R6: A write to offset 0 or 2 whose value equals the stored value is not forwarded. Control is stored with bits 7:6 forced to 1, and the stored values read back.
- R7: When a control write changes bit 5 (direction), a beat of kind 2 carrying the new bit 5 in bit 0 is issued before the control beat.
- R8: A beat acknowledged within `cfg_wait_limit` cycles of its request succeeds. Otherwise the access ends, the timeout flag is set, and any remaining bytes are abandoned.
- R9: The timeout flag stays set until a write to offset 1 with data bit 0 equal to 1. A write to offset 1 with bit 0 equal to 0 leaves it unchanged.
- R10: An offset-1 read returns `per_status_hi` in bits 7:1 and the timeout flag in bit 0.
- R11: Reset clears the timeout flag and restores the control byte.
- R12: Reads of offsets 5 to 7 return all ones. Writes to offsets 5 to 7 change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_wait_limit | input | TMO_W | Cycles allowed per beat for the acknowledge |
| host_req | input | 1 | Access request, taken when host_ready is high |
| host_we | input | 1 | 1 = write, 0 = read |
| host_addr | input | 3 | Register offset |
| host_size | input | 2 | 0 byte, 1 half, 2 word (offset 4 only) |
| host_wdata | input | DATA_W | Write data |
| host_ready | output | 1 | High when a new access can be taken |
| host_done | output | 1 | One-cycle completion pulse |
| host_rdata | output | DATA_W | Read result, valid with host_done |
| per_status_hi | input | 7 | Peripheral status lines for bits 7:1 |
| per_req | output | 1 | Beat request to the peripheral |
| per_kind | output | 3 | Beat kind code |
| per_byte | output | 8 | Byte sent with the beat |
| per_ack | input | 1 | Beat acknowledge |
| per_rbyte | input | 8 | Byte returned on read beats |

## Verification
The bench sweeps control patterns that are one bit away from each gate pattern. A gate that decodes too few bits would forward those cycles and let the peripheral see requests it should never see. It sets the acknowledge delay to exactly one less than the limit and then exactly equal to it, which catches an off-by-one in the wait counter as a spurious or a missing timeout. A multi-byte access is starved after two bytes to show that the remainder is abandoned and reads keep 0xFF in the lost lanes. A direction-changing control write is checked for beat order, since a design that reversed the order would send the control byte first.

// File: rtl/epp_gate_pkg.sv
package epp_gate_pkg;
  typedef enum logic [2:0] {
    K_DATA_WR = 3'd0,
    K_CTRL_WR = 3'd1,
    K_DIR_CHG = 3'd2,
    K_EPPA_WR = 3'd3,
    K_EPPD_WR = 3'd4,
    K_EPPA_RD = 3'd5,
    K_EPPD_RD = 3'd6
  } fwd_kind_e;

  localparam logic [2:0] OFS_DATA = 3'd0;
  localparam logic [2:0] OFS_STAT = 3'd1;
  localparam logic [2:0] OFS_CTRL = 3'd2;
  localparam logic [2:0] OFS_EPPA = 3'd3;
  localparam logic [2:0] OFS_EPPD = 3'd4;

  localparam logic [7:0] GATE_MASK  = 8'h2F;
  localparam logic [7:0] GATE_WR    = 8'h04;
  localparam logic [7:0] GATE_RD    = 8'h24;
  localparam logic [7:0] CTRL_FIXED = 8'hC0;
  localparam int         DIR_POS    = 5;
  localparam logic [7:0] RST_CTRL   = 8'hCC;
  localparam logic [7:0] RST_DATA   = 8'hFF;
endpackage

// File: rtl/epp_access_decode.sv
module epp_access_decode
  import epp_gate_pkg::*;
#(
  parameter int DATA_W = 32,
  localparam int BYTES  = DATA_W / 8,
  localparam int BEAT_W = $clog2(BYTES + 1)
) (
  input  logic              we,
  input  logic [2:0]        addr,
  input  logic [1:0]        size,
  input  logic [DATA_W-1:0] wdata,
  input  logic [7:0]        ctrl_q,
  input  logic [7:0]        data_q,
  input  logic              tmo_q,
  input  logic [7:1]        status_hi,
  output logic              fwd,
  output fwd_kind_e         kind,
  output logic [BEAT_W-1:0] beats,
  output logic [DATA_W-1:0] payload,
  output logic              upd_data,
  output logic              upd_ctrl,
  output logic [7:0]        ctrl_new,
  output logic              clr_tmo,
  output logic [7:0]        imm_byte
);
  logic [7:0]        masked;
  logic              wr_ok;
  logic              rd_ok;
  logic [BEAT_W-1:0] size_beats;

  assign masked   = ctrl_q & GATE_MASK;
  assign wr_ok    = (masked == GATE_WR);
  assign rd_ok    = (masked == GATE_RD);
  assign ctrl_new = wdata[7:0] | CTRL_FIXED;

  always_comb begin
    case (size)
      2'd0:    size_beats = BEAT_W'(1);
      2'd1:    size_beats = BEAT_W'((BYTES >= 2) ? 2 : BYTES);
      default: size_beats = BEAT_W'(BYTES);
    endcase
  end

  always_comb begin
    fwd      = 1'b0;
    kind     = K_DATA_WR;
    beats    = BEAT_W'(1);
    payload  = DATA_W'(wdata[7:0]);
    upd_data = 1'b0;
    upd_ctrl = 1'b0;
    clr_tmo  = 1'b0;
    imm_byte = 8'hFF;
    if (we) begin
      case (addr)
        OFS_DATA: begin
          upd_data = 1'b1;
          fwd      = (wdata[7:0] != data_q);
          kind     = K_DATA_WR;
        end
        OFS_STAT: clr_tmo = wdata[0];
        OFS_CTRL: begin
          upd_ctrl = 1'b1;
          fwd      = (ctrl_new != ctrl_q);
          if (ctrl_new[DIR_POS] != ctrl_q[DIR_POS]) begin
            kind    = K_DIR_CHG;
            beats   = BEAT_W'(2);
            payload = DATA_W'({ctrl_new, 7'b0, ctrl_new[DIR_POS]});
          end else begin
            kind    = K_CTRL_WR;
            payload = DATA_W'(ctrl_new);
          end
        end
        OFS_EPPA: begin
          fwd  = wr_ok;
          kind = K_EPPA_WR;
        end
        OFS_EPPD: begin
          fwd     = wr_ok;
          kind    = K_EPPD_WR;
          beats   = size_beats;
          payload = wdata;
        end
        default: ;
      endcase
    end else begin
      case (addr)
        OFS_DATA: imm_byte = data_q;
        OFS_STAT: imm_byte = {status_hi, tmo_q};
        OFS_CTRL: imm_byte = ctrl_q;
        OFS_EPPA: begin
          fwd  = rd_ok;
          kind = K_EPPA_RD;
        end
        OFS_EPPD: begin
          fwd   = rd_ok;
          kind  = K_EPPD_RD;
          beats = size_beats;
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/epp_beat_engine.sv
module epp_beat_engine
  import epp_gate_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int TMO_W  = 16,
  localparam int BYTES  = DATA_W / 8,
  localparam int BEAT_W = $clog2(BYTES + 1),
  localparam int IDX_W  = (BYTES > 1) ? $clog2(BYTES) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  fwd_kind_e         start_kind,
  input  logic [BEAT_W-1:0] start_beats,
  input  logic [DATA_W-1:0] start_payload,
  input  logic [TMO_W-1:0]  wait_limit,
  input  logic              per_ack,
  input  logic [7:0]        per_rbyte,
  output logic              busy_o,
  output fwd_kind_e         kind_o,
  output logic [7:0]        byte_o,
  output logic              fin_o,
  output logic              fail_set_o,
  output logic [DATA_W-1:0] col_o
);
  logic              busy_q;
  fwd_kind_e         kind_q;
  logic [BEAT_W-1:0] left_q;
  logic [IDX_W-1:0]  idx_q;
  logic [DATA_W-1:0] sh_q;
  logic [TMO_W-1:0]  cnt_q;
  logic              fin_q;
  logic              limit_hit;
  logic              is_rd;
  logic              load;

  assign limit_hit  = (wait_limit == '0) || (cnt_q == wait_limit - 1'b1);
  assign fail_set_o = busy_q && !per_ack && limit_hit;
  assign is_rd      = (kind_q == K_EPPA_RD) || (kind_q == K_EPPD_RD);
  assign load       = !busy_q && start;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q <= 1'b0;
      kind_q <= K_DATA_WR;
      left_q <= '0;
      idx_q  <= '0;
      sh_q   <= '0;
      cnt_q  <= '0;
      fin_q  <= 1'b0;
    end else begin
      fin_q <= 1'b0;
      if (load) begin
        busy_q <= 1'b1;
        kind_q <= start_kind;
        left_q <= start_beats;
        idx_q  <= '0;
        sh_q   <= start_payload;
        cnt_q  <= '0;
      end else if (busy_q) begin
        if (per_ack) begin
          if (left_q == BEAT_W'(1)) begin
            busy_q <= 1'b0;
            fin_q  <= 1'b1;
          end else begin
            left_q <= left_q - 1'b1;
            idx_q  <= idx_q + 1'b1;
            sh_q   <= sh_q >> 8;
            cnt_q  <= '0;
            if (kind_q == K_DIR_CHG) kind_q <= K_CTRL_WR;
          end
        end else if (limit_hit) begin
          busy_q <= 1'b0;
          fin_q  <= 1'b1;
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end
    end
  end

  for (genvar g = 0; g < BYTES; g++) begin : g_lane
    always_ff @(posedge clk) begin
      if (rst || load)
        col_o[g*8 +: 8] <= 8'hFF;
      else if (busy_q && per_ack && is_rd && idx_q == IDX_W'(g))
        col_o[g*8 +: 8] <= per_rbyte;
    end
  end

  assign busy_o = busy_q;
  assign kind_o = kind_q;
  assign byte_o = sh_q[7:0];
  assign fin_o  = fin_q;

  AST_BEAT_STABLE: assert property (@(posedge clk) disable iff (rst)
    (busy_q && !per_ack && !limit_hit) |=> (busy_q && $stable(kind_q) && $stable(sh_q[7:0]))); // R4
  AST_FAIL_ENDS: assert property (@(posedge clk) disable iff (rst)
    fail_set_o |=> (!busy_q && fin_q)); // R8
endmodule

// File: rtl/epp_cycle_gate.sv
module epp_cycle_gate
  import epp_gate_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int TMO_W  = 16,
  localparam int BYTES  = DATA_W / 8,
  localparam int BEAT_W = $clog2(BYTES + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [TMO_W-1:0]  cfg_wait_limit,
  input  logic              host_req,
  input  logic              host_we,
  input  logic [2:0]        host_addr,
  input  logic [1:0]        host_size,
  input  logic [DATA_W-1:0] host_wdata,
  output logic              host_ready,
  output logic              host_done,
  output logic [DATA_W-1:0] host_rdata,
  input  logic [7:1]        per_status_hi,
  output logic              per_req,
  output logic [2:0]        per_kind,
  output logic [7:0]        per_byte,
  input  logic              per_ack,
  input  logic [7:0]        per_rbyte
);
  logic [7:0]        data_q;
  logic [7:0]        ctrl_q;
  logic              tmo_q;
  logic              imm_done_q;
  logic [DATA_W-1:0] imm_rd_q;

  logic              accept;
  logic              d_fwd;
  fwd_kind_e         d_kind;
  logic [BEAT_W-1:0] d_beats;
  logic [DATA_W-1:0] d_payload;
  logic              d_upd_data;
  logic              d_upd_ctrl;
  logic [7:0]        d_ctrl_new;
  logic              d_clr_tmo;
  logic [7:0]        d_imm_byte;

  logic              eng_busy;
  fwd_kind_e         eng_kind;
  logic [7:0]        eng_byte;
  logic              eng_fin;
  logic              eng_fail_set;
  logic [DATA_W-1:0] eng_col;

  assign accept = host_req && !eng_busy;

  epp_access_decode #(.DATA_W(DATA_W)) u_decode (
    .we        (host_we),
    .addr      (host_addr),
    .size      (host_size),
    .wdata     (host_wdata),
    .ctrl_q    (ctrl_q),
    .data_q    (data_q),
    .tmo_q     (tmo_q),
    .status_hi (per_status_hi),
    .fwd       (d_fwd),
    .kind      (d_kind),
    .beats     (d_beats),
    .payload   (d_payload),
    .upd_data  (d_upd_data),
    .upd_ctrl  (d_upd_ctrl),
    .ctrl_new  (d_ctrl_new),
    .clr_tmo   (d_clr_tmo),
    .imm_byte  (d_imm_byte)
  );

  epp_beat_engine #(.DATA_W(DATA_W), .TMO_W(TMO_W)) u_engine (
    .clk           (clk),
    .rst           (rst),
    .start         (accept && d_fwd),
    .start_kind    (d_kind),
    .start_beats   (d_beats),
    .start_payload (d_payload),
    .wait_limit    (cfg_wait_limit),
    .per_ack       (per_ack),
    .per_rbyte     (per_rbyte),
    .busy_o        (eng_busy),
    .kind_o        (eng_kind),
    .byte_o        (eng_byte),
    .fin_o         (eng_fin),
    .fail_set_o    (eng_fail_set),
    .col_o         (eng_col)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      data_q     <= RST_DATA;
      ctrl_q     <= RST_CTRL;
      tmo_q      <= 1'b0;
      imm_done_q <= 1'b0;
      imm_rd_q   <= '1;
    end else begin
      imm_done_q <= accept && !d_fwd;
      if (accept && !d_fwd) imm_rd_q <= {{(DATA_W-8){1'b1}}, d_imm_byte};
      if (accept && d_upd_data) data_q <= host_wdata[7:0];
      if (accept && d_upd_ctrl) ctrl_q <= d_ctrl_new;
      if (eng_fail_set)                tmo_q <= 1'b1;
      else if (accept && d_clr_tmo)    tmo_q <= 1'b0;
    end
  end

  assign host_ready = !eng_busy;
  assign host_done  = imm_done_q | eng_fin;
  assign host_rdata = eng_fin ? eng_col : imm_rd_q;
  assign per_req    = eng_busy;
  assign per_kind   = eng_kind;
  assign per_byte   = eng_byte;

  AST_WR_GATE: assert property (@(posedge clk) disable iff (rst)
    (accept && host_we && (host_addr == OFS_EPPA || host_addr == OFS_EPPD) &&
     ((ctrl_q & GATE_MASK) != GATE_WR)) |=> (!per_req && host_done)); // R2
  AST_RD_GATE: assert property (@(posedge clk) disable iff (rst)
    (accept && !host_we && (host_addr == OFS_EPPA || host_addr == OFS_EPPD) &&
     ((ctrl_q & GATE_MASK) != GATE_RD)) |=> (!per_req && host_rdata == '1)); // R3
  AST_TMO_HOLD: assert property (@(posedge clk) disable iff (rst)
    (tmo_q && !(accept && host_we && host_addr == OFS_STAT && host_wdata[0])) |=> tmo_q); // R9
  AST_FAIL_SETS: assert property (@(posedge clk) disable iff (rst)
    (per_req && !per_ack && !host_ready && eng_fail_set) |=> (tmo_q && host_ready)); // R8
  AST_DIR_FIRST: assert property (@(posedge clk) disable iff (rst)
    (accept && host_we && host_addr == OFS_CTRL &&
     (host_wdata[DIR_POS] != ctrl_q[DIR_POS])) |=>
    (per_req && per_kind == 3'd2 && per_byte[0] == $past(host_wdata[DIR_POS]))); // R7
  AST_RST_CLEAR: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (!tmo_q && ctrl_q == RST_CTRL)); // R11
endmodule

// File: tb/epp_cycle_gate_bench.sv
module epp_cycle_gate_bench;
  typedef struct packed {
    logic        we;
    logic [2:0]  addr;
    logic [1:0]  size;
    logic [31:0] wdata;
    logic [31:0] exp_rd;
    logic [2:0]  exp_n;
    logic [2:0]  exp_k;
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 21;
  localparam vec_t TBL [NV] = '{
    '{1'b0, 3'd2, 2'd0, 32'h0,        32'hFFFFFFCC, 3'd0, 3'd0, 4'd1},  // R1 control reset
    '{1'b0, 3'd0, 2'd0, 32'h0,        32'hFFFFFFFF, 3'd0, 3'd0, 4'd1},  // R1 data reset
    '{1'b1, 3'd4, 2'd0, 32'h55,       32'hFFFFFFFF, 3'd0, 3'd0, 4'd2},  // R2 gated write
    '{1'b1, 3'd2, 2'd0, 32'h04,       32'hFFFFFFFF, 3'd1, 3'd1, 4'd4},  // R4 control beat
    '{1'b1, 3'd2, 2'd0, 32'h04,       32'hFFFFFFFF, 3'd0, 3'd0, 4'd6},  // R6 same control
    '{1'b1, 3'd0, 2'd0, 32'h12,       32'hFFFFFFFF, 3'd1, 3'd0, 4'd4},  // R4 data beat
    '{1'b1, 3'd0, 2'd0, 32'h12,       32'hFFFFFFFF, 3'd0, 3'd0, 4'd6},  // R6 same data
    '{1'b0, 3'd0, 2'd0, 32'h0,        32'hFFFFFF12, 3'd0, 3'd0, 4'd6},  // R6 data readback
    '{1'b1, 3'd3, 2'd0, 32'h3A,       32'hFFFFFFFF, 3'd1, 3'd3, 4'd2},  // R2 address write
    '{1'b1, 3'd4, 2'd2, 32'h44332211, 32'hFFFFFFFF, 3'd4, 3'd4, 4'd5},  // R5 word write
    '{1'b0, 3'd3, 2'd0, 32'h0,        32'hFFFFFFFF, 3'd0, 3'd0, 4'd3},  // R3 gated read
    '{1'b1, 3'd2, 2'd0, 32'h24,       32'hFFFFFFFF, 3'd2, 3'd2, 4'd7},  // R7 direction
    '{1'b0, 3'd4, 2'd1, 32'h0,        32'hFFFFD1D0, 3'd2, 3'd6, 4'd5},  // R5 half read
    '{1'b0, 3'd3, 2'd0, 32'h0,        32'hFFFFFFD0, 3'd1, 3'd5, 4'd3},  // R3 address read
    '{1'b1, 3'd4, 2'd0, 32'h77,       32'hFFFFFFFF, 3'd0, 3'd0, 4'd2},  // R2 gated in read mode
    '{1'b0, 3'd1, 2'd0, 32'h0,        32'hFFFFFFA6, 3'd0, 3'd0, 4'd10}, // R10 status
    '{1'b0, 3'd4, 2'd2, 32'h0,        32'hD3D2D1D0, 3'd4, 3'd6, 4'd5},  // R5 word read
    '{1'b0, 3'd2, 2'd0, 32'h0,        32'hFFFFFFE4, 3'd0, 3'd0, 4'd6},  // R6 control readback
    '{1'b0, 3'd6, 2'd0, 32'h0,        32'hFFFFFFFF, 3'd0, 3'd0, 4'd12}, // R12 unused read
    '{1'b1, 3'd6, 2'd0, 32'h99,       32'hFFFFFFFF, 3'd0, 3'd0, 4'd12}, // R12 unused write
    '{1'b0, 3'd0, 2'd0, 32'h0,        32'hFFFFFF12, 3'd0, 3'd0, 4'd12}  // R12 state unchanged
  };

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] cfg_wait_limit = 16'd8;
  logic        host_req = 1'b0;
  logic        host_we = 1'b0;
  logic [2:0]  host_addr = 3'd0;
  logic [1:0]  host_size = 2'd0;
  logic [31:0] host_wdata = 32'h0;
  logic        host_ready;
  logic        host_done;
  logic [31:0] host_rdata;
  logic [7:1]  per_status_hi = 7'h53;
  logic        per_req;
  logic [2:0]  per_kind;
  logic [7:0]  per_byte;
  logic        per_ack = 1'b0;
  logic [7:0]  per_rbyte;

  int checks = 0;
  int errors = 0;

  int ack_delay = 1;
  int ack_budget = 1000;
  int wait_n = 0;
  int mbeat = 0;
  int log_n = 0;
  logic [2:0] log_kind [64];
  logic [7:0] log_byte [64];

  always #4 clk = ~clk;

  epp_cycle_gate u_epp_cycle_gate (
    .clk(clk), .rst(rst), .cfg_wait_limit(cfg_wait_limit),
    .host_req(host_req), .host_we(host_we), .host_addr(host_addr),
    .host_size(host_size), .host_wdata(host_wdata), .host_ready(host_ready),
    .host_done(host_done), .host_rdata(host_rdata), .per_status_hi(per_status_hi),
    .per_req(per_req), .per_kind(per_kind), .per_byte(per_byte),
    .per_ack(per_ack), .per_rbyte(per_rbyte)
  );

  assign per_rbyte = 8'hD0 | 8'(mbeat & 3);

  always @(negedge clk) begin
    if (per_ack) begin
      per_ack <= 1'b0;
      wait_n  <= 0;
      mbeat   <= mbeat + 1;
    end else if (per_req) begin
      if (wait_n == ack_delay && ack_budget > 0) begin
        per_ack    <= 1'b1;
        ack_budget <= ack_budget - 1;
        log_kind[log_n % 64] <= per_kind;
        log_byte[log_n % 64] <= per_byte;
        log_n <= log_n + 1;
      end else begin
        wait_n <= wait_n + 1;
      end
    end else begin
      wait_n <= 0;
      mbeat  <= 0;
    end
  end

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic access(input logic we, input logic [2:0] a, input logic [1:0] s,
                        input logic [31:0] wd, output logic [31:0] rd,
                        output int nf, output logic busy_seen);
    int n0;
    int guard;
    @(negedge clk);
    n0 = log_n;
    host_req = 1'b1; host_we = we; host_addr = a; host_size = s; host_wdata = wd;
    @(posedge clk);
    @(negedge clk);
    host_req = 1'b0;
    busy_seen = !host_ready && per_req;
    guard = 0;
    while (!host_done && guard < 1000) begin
      @(negedge clk);
      guard++;
    end
    rd = host_rdata;
    @(negedge clk);
    nf = log_n - n0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual hung expected done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] rd;
    int nf;
    logic bs;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    check("R1 ready after reset", 32'(host_ready), 32'd1);
    check("R1 no request after reset", 32'(per_req), 32'd0);
    check("R1 no done after reset", 32'(host_done), 32'd0);

    for (int i = 0; i < NV; i++) begin
      int k0;
      k0 = log_n;
      access(TBL[i].we, TBL[i].addr, TBL[i].size, TBL[i].wdata, rd, nf, bs);
      check($sformatf("R%0d row %0d rdata", TBL[i].req, i), rd, TBL[i].exp_rd);
      check($sformatf("R%0d row %0d beats", TBL[i].req, i), 32'(nf), 32'(TBL[i].exp_n));
      if (TBL[i].exp_n != 0)
        check($sformatf("R%0d row %0d first kind", TBL[i].req, i),
              32'(log_kind[k0 % 64]), 32'(TBL[i].exp_k));
    end

    // R7: leaving read mode, direction beat then control beat
    begin
      int k0;
      k0 = log_n;
      access(1'b1, 3'd2, 2'd0, 32'h04, rd, nf, bs);
      check("R7 beats", 32'(nf), 32'd2);
      check("R7 first kind", 32'(log_kind[k0 % 64]), 32'd2);
      check("R7 first byte", 32'(log_byte[k0 % 64]), 32'h00);
      check("R7 second kind", 32'(log_kind[(k0+1) % 64]), 32'd1);
      check("R7 second byte", 32'(log_byte[(k0+1) % 64]), 32'hC4);
      k0 = log_n;
      access(1'b1, 3'd4, 2'd1, 32'h0000BEEF, rd, nf, bs);
      check("R5 low byte first", 32'(log_byte[k0 % 64]), 32'hEF);
      check("R5 high byte second", 32'(log_byte[(k0+1) % 64]), 32'hBE);
    end

    // R8: acknowledge on the last allowed cycle succeeds
    cfg_wait_limit = 16'd4;
    ack_delay = 3;
    access(1'b1, 3'd3, 2'd0, 32'h11, rd, nf, bs);
    check("R8 late ack accepted", 32'(nf), 32'd1);
    access(1'b0, 3'd1, 2'd0, 32'h0, rd, nf, bs);
    check("R8 no timeout at limit", rd, 32'hFFFFFFA6);
    // R8: one cycle later fails
    ack_delay = 4;
    access(1'b1, 3'd3, 2'd0, 32'h22, rd, nf, bs);
    check("R4 ready low during beat", 32'(bs), 32'd1);
    check("R8 missing ack forwards nothing", 32'(nf), 32'd0);
    access(1'b0, 3'd1, 2'd0, 32'h0, rd, nf, bs);
    check("R8 R10 timeout in status", rd, 32'hFFFFFFA7);

    // R9: bit 0 clear keeps the flag, bit 0 set clears it
    ack_delay = 1;
    cfg_wait_limit = 16'd8;
    access(1'b1, 3'd1, 2'd0, 32'hFE, rd, nf, bs);
    access(1'b0, 3'd1, 2'd0, 32'h0, rd, nf, bs);
    check("R9 sticky", rd, 32'hFFFFFFA7);
    access(1'b1, 3'd1, 2'd0, 32'h01, rd, nf, bs);
    access(1'b0, 3'd1, 2'd0, 32'h0, rd, nf, bs);
    check("R9 cleared", rd, 32'hFFFFFFA6);

    // R8: multi-byte access starved after two bytes
    ack_budget = 2;
    access(1'b1, 3'd4, 2'd2, 32'hCAFEF00D, rd, nf, bs);
    check("R8 abandoned remainder", 32'(nf), 32'd2);
    check("R8 request dropped", 32'(per_req), 32'd0);
    access(1'b0, 3'd1, 2'd0, 32'h0, rd, nf, bs);
    check("R8 partial sets timeout", rd, 32'hFFFFFFA7);
    ack_budget = 1000;

    // R11: reset clears the flag and control
    @(negedge clk);
    rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    access(1'b0, 3'd1, 2'd0, 32'h0, rd, nf, bs);
    check("R11 timeout cleared", rd, 32'hFFFFFFA6);
    access(1'b0, 3'd2, 2'd0, 32'h0, rd, nf, bs);
    check("R11 control restored", rd, 32'hFFFFFFCC);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule